// File: doc/BRIEF.md
# Zero-Check Framing Guard

This block sits on the receive side of a scrambled serial link, after the descrambler. It takes one 18-bit word per valid strobe and checks the framing rules that let the receiver find corrupted traffic without a per-frame CRC. Bit 16 of each word is the control/data flag, bits 15:0 carry the payload, and bit 17 must always be 0. Wherever the flag changes value, the first word after the change has to carry all-zero payload bits (a zero-check word). A control word is framed by a zero word with the flag at 1, one or more control words with the flag at 1, and a zero word with the flag back at 0. Between these, data words run in bursts of a configured length, each burst closed by a two-word flag blip of zero words.

Accepted data and control words wait in a quarantine shift buffer. They leave it only when a set number of further words has been accepted with no error. On any framing error the guard pulses an error output and a retransmit request, drops everything in quarantine and hunts for the next zero-check pair before it accepts words again.

The FSM states are `ST_IDLE` (after reset, configuration is captured), `ST_HUNT` (waiting for a zero word with the flag at 1), `ST_ARMED` (that word was seen, and a zero word with the flag at 0 is needed), `ST_STREAM` (data words are counted), `ST_OPEN` (a flag-1 zero word opened a check) and `ST_CONTROL` (control words are being received). The transitions are as follows. IDLE/HUNT go to ARMED on a flag-1 zero word. ARMED goes to STREAM on a flag-0 zero word, stays in ARMED on another flag-1 zero word, and returns to HUNT on any other word. STREAM goes to OPEN on a flag-1 zero word at the burst limit. OPEN goes to STREAM on a flag-0 zero word and to CONTROL on a flag-1 word. CONTROL stays in CONTROL on flag-1 words and goes to STREAM on a flag-0 zero word. Every failure from STREAM, OPEN or CONTROL goes to HUNT.

Top module: `frame_guard`

## Requirements
- R1: A word is decoded as bit 17 = must-be-zero bit, bit 16 = control/data flag, bits 15:0 = payload. In STREAM, OPEN and CONTROL, the first word after a flag change must have all-zero payload bits, otherwise an error is raised.
- R2: After reset or after an error, words raise no framing error and are not accepted until a zero word with the flag at 1 is directly followed by a zero word with the flag at 0. Repeated flag-1 zero words keep the hunt armed.
- R3: The burst limit is 8 shifted left by the 2-bit interval setting (0:8, 1:16, 2:32, 3:64). A change of the flag from 0 to 1 is accepted only when exactly that many data words have been received since the last completed check. An earlier toggle is an error.
- R4: A data word that arrives when the burst limit has already been reached (a missing check pair) is an error.
- R5: After a flag-1 zero word, further flag-1 words are control words. A flag-0 zero word closes the check or the control frame and restarts the burst count at zero.
- R6: A word with bit 17 set pulses the error output in every state. It requests a retransmission only when the guard is synchronised (STREAM, OPEN, CONTROL). In the hunt states it restarts the hunt.
- R7: On an error, the error pulse and the retransmit request are high for exactly the one cycle after the offending word. The quarantine is emptied and the guard returns to HUNT.
- R8: Each accepted data or control word is released as {flag, payload} on the release output one cycle after the depth-th following word is accepted. Check words take a quarantine slot but are never released.
- R9: Configuration bit depth selects a quarantine depth of 16 (0) or 32 (1). Both depth and interval are sampled only in IDLE after reset. Changes at any other time have no effect.
- R10: A word that raises an error releases nothing, even if the oldest quarantined word was due.
- R11: During and directly after reset, release valid, error and retransmit outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe for in_word |
| in_word | input | 18 | Descrambled word: [17] zero bit, [16] flag, [15:0] payload |
| cfg_deep | input | 1 | Quarantine depth select (0:16, 1:32), sampled in IDLE |
| cfg_interval | input | 2 | Burst limit select, 8 << value, sampled in IDLE |
| rel_valid | output | 1 | A quarantined word is released |
| rel_word | output | 17 | Released {flag, payload} |
| err_pulse | output | 1 | Framing error pulse |
| retx_req | output | 1 | Retransmit request pulse |

## Verification
Error and retransmit pulses are due in the cycle right after the clock edge that takes the offending word, so each word is driven at a falling edge and every output is sampled at the next falling edge. A release falls in that same sampling slot. It belongs to the word accepted depth words earlier, counted in accepted words rather than cycles, so the expected release at each step follows from the index of the word in the current synchronised run. Runs of 16 and 32 words, including check slots inside the window, confirm this delay. After a flush, 16 clean words with no release show that nothing discarded comes out later.

// File: rtl/fg_pkg.sv
package fg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HUNT,
        ST_ARMED,
        ST_STREAM,
        ST_OPEN,
        ST_CONTROL
    } fg_state_e;

    typedef struct packed {
        logic top;   // must-be-zero bit is set
        logic flag;  // control/data flag
        logic zero;  // payload bits are all zero
    } fg_info_t;

endpackage

// File: rtl/fg_word_decode.sv
module fg_word_decode
    import fg_pkg::*;
#(
    parameter int WORD_W = 18,
    parameter int DATA_W = 16
) (
    input  logic [WORD_W-1:0] word,
    output fg_info_t          info
);

    localparam int FLAG_BIT = DATA_W;

    always_comb begin
        info.zero = ~|word[DATA_W-1:0];
        info.flag = word[FLAG_BIT];
        info.top  = |word[WORD_W-1:FLAG_BIT+1];
    end

endmodule

// File: rtl/fg_gap_counter.sv
module fg_gap_counter #(
    parameter int GAP_BASE  = 8,
    parameter int GAP_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 inc,
    input  logic [GAP_SEL_W-1:0] sel,
    output logic                 at_limit
);

    localparam int MAX_GAP = GAP_BASE << ((1 << GAP_SEL_W) - 1);
    localparam int CNT_W   = $clog2(MAX_GAP) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit    = CNT_W'(GAP_BASE) << sel;
        at_limit = (cnt == limit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/fg_quarantine.sv
module fg_quarantine #(
    parameter int ENT_W      = 17,
    parameter int SHALLOW    = 16,
    parameter int DEEP       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             push,
    input  logic [ENT_W-1:0] din,
    input  logic             flush,
    input  logic             deep,
    output logic             rel_valid,
    output logic [ENT_W-1:0] rel_word
);

    logic [DEEP-1:0]  vld;
    logic [ENT_W-1:0] dat [DEEP];
    logic             tail_v;
    logic [ENT_W-1:0] tail_d;

    always_comb begin
        tail_v = deep ? vld[DEEP-1] : vld[SHALLOW-1];
        tail_d = deep ? dat[DEEP-1] : dat[SHALLOW-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld[0] <= 1'b0;
        end else if (adv) begin
            vld[0] <= push;
            dat[0] <= din;
        end
    end

    for (genvar k = 1; k < DEEP; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld[k] <= 1'b0;
            end else if (adv) begin
                vld[k] <= vld[k-1];
                dat[k] <= dat[k-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rel_valid <= 1'b0;
            rel_word  <= '0;
        end else begin
            rel_valid <= adv && tail_v;
            rel_word  <= tail_d;
        end
    end

endmodule

// File: rtl/fg_fsm.sv
module fg_fsm
    import fg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     in_valid,
    input  fg_info_t info,
    input  logic     at_limit,
    output logic     adv,
    output logic     push,
    output logic     cnt_clr,
    output logic     cnt_inc,
    output logic     flush,
    output logic     err_now,
    output logic     retx_now,
    output logic     latch_cfg
);

    fg_state_e state, state_nx;
    logic      synced;
    logic      fail;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        synced = (state == ST_STREAM) || (state == ST_OPEN) || (state == ST_CONTROL);
        fail   = 1'b0;
        if (in_valid && synced) begin
            if (info.top) begin
                fail = 1'b1;
            end else if (state == ST_STREAM) begin
                fail = info.flag ? (!at_limit || !info.zero) : at_limit;
            end else begin
                fail = !info.flag && !info.zero;
            end
        end
    end

    always_comb begin
        state_nx = state;
        if (in_valid) begin
            unique case (state)
                ST_IDLE, ST_HUNT: begin
                    if (!info.top && info.flag && info.zero) state_nx = ST_ARMED;
                    else                                     state_nx = ST_HUNT;
                end
                ST_ARMED: begin
                    if (info.top || !info.zero) state_nx = ST_HUNT;
                    else if (info.flag)         state_nx = ST_ARMED;
                    else                        state_nx = ST_STREAM;
                end
                ST_STREAM: begin
                    if (fail)           state_nx = ST_HUNT;
                    else if (info.flag) state_nx = ST_OPEN;
                    else                state_nx = ST_STREAM;
                end
                ST_OPEN, ST_CONTROL: begin
                    if (fail)           state_nx = ST_HUNT;
                    else if (info.flag) state_nx = ST_CONTROL;
                    else                state_nx = ST_STREAM;
                end
                default: state_nx = ST_HUNT;
            endcase
        end
    end

    always_comb begin
        latch_cfg = (state == ST_IDLE);
        flush     = fail;
        retx_now  = fail;
        err_now   = fail || (in_valid && !synced && info.top);
        adv       = in_valid && synced && !fail;
        push      = adv && ((state == ST_STREAM) ? !info.flag : info.flag);
        cnt_inc   = adv && (state == ST_STREAM) && !info.flag;
        cnt_clr   = (in_valid && (state == ST_ARMED) && !info.top && info.zero && !info.flag)
                 || (adv && (state != ST_STREAM) && !info.flag);
    end

endmodule

// File: rtl/frame_guard.sv
module frame_guard
    import fg_pkg::*;
#(
    parameter int WORD_W    = 18,
    parameter int DATA_W    = 16,
    parameter int GAP_BASE  = 8,
    parameter int GAP_SEL_W = 2,
    parameter int SHALLOW   = 16,
    parameter int DEEP      = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [WORD_W-1:0]    in_word,
    input  logic                 cfg_deep,
    input  logic [GAP_SEL_W-1:0] cfg_interval,
    output logic                 rel_valid,
    output logic [DATA_W:0]      rel_word,
    output logic                 err_pulse,
    output logic                 retx_req
);

    localparam int ENT_W = DATA_W + 1;

    fg_info_t             info;
    logic                 at_limit;
    logic                 adv, push, cnt_clr, cnt_inc, flush;
    logic                 err_now, retx_now, latch_cfg;
    logic                 deep_q;
    logic [GAP_SEL_W-1:0] sel_q;

    fg_word_decode #(.WORD_W(WORD_W), .DATA_W(DATA_W)) u_decode (
        .word (in_word),
        .info (info)
    );

    fg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .info      (info),
        .at_limit  (at_limit),
        .adv       (adv),
        .push      (push),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .flush     (flush),
        .err_now   (err_now),
        .retx_now  (retx_now),
        .latch_cfg (latch_cfg)
    );

    fg_gap_counter #(.GAP_BASE(GAP_BASE), .GAP_SEL_W(GAP_SEL_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .sel      (sel_q),
        .at_limit (at_limit)
    );

    fg_quarantine #(.ENT_W(ENT_W), .SHALLOW(SHALLOW), .DEEP(DEEP)) u_quar (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .push      (push),
        .din       (in_word[DATA_W:0]),
        .flush     (flush),
        .deep      (deep_q),
        .rel_valid (rel_valid),
        .rel_word  (rel_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_q    <= 1'b0;
            sel_q     <= '0;
            err_pulse <= 1'b0;
            retx_req  <= 1'b0;
        end else begin
            if (latch_cfg) begin
                deep_q <= cfg_deep;
                sel_q  <= cfg_interval;
            end
            err_pulse <= err_now;
            retx_req  <= retx_now;
        end
    end

endmodule

// File: rtl/frame_guard_sva.sv
module frame_guard_sva #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_word,
    input logic              rel_valid,
    input logic              err_pulse,
    input logic              retx_req
);

    AST_RETX_WITH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |-> err_pulse);  // R7

    AST_RETX_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        retx_req |=> !retx_req);  // R7

    AST_TOP_BIT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[WORD_W-1]) |=> err_pulse);  // R6

    AST_NO_REL_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse |-> !rel_valid);  // R10

    AST_REL_NEEDS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> $past(in_valid));  // R8

endmodule

bind frame_guard frame_guard_sva #(.WORD_W(WORD_W)) u_frame_guard_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_word   (in_word),
    .rel_valid (rel_valid),
    .err_pulse (err_pulse),
    .retx_req  (retx_req)
);

// File: tb/test_frame_guard.sv
module test_frame_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [17:0] in_word = '0;
    logic        cfg_deep = 1'b0;
    logic [1:0]  cfg_interval = 2'd0;
    logic        rel_valid;
    logic [16:0] rel_word;
    logic        err_pulse;
    logic        retx_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    frame_guard i_frame_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .cfg_deep     (cfg_deep),
        .cfg_interval (cfg_interval),
        .rel_valid    (rel_valid),
        .rel_word     (rel_word),
        .err_pulse    (err_pulse),
        .retx_req     (retx_req)
    );

    typedef struct packed {
        logic [17:0] w;
        logic        e;
        logic        r;
        logic        v;
        logic [16:0] q;
    } vec_t;

    localparam int NV = 41;
    localparam vec_t TBL [NV] = '{
        '{18'h00123, 1'b0, 1'b0, 1'b0, 17'h0},      // R2 hunting, ignored
        '{18'h10000, 1'b0, 1'b0, 1'b0, 17'h0},      // R2
        '{18'h00000, 1'b0, 1'b0, 1'b0, 17'h0},      // R2 synced
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0AAAA, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h10000, 1'b0, 1'b0, 1'b0, 17'h0},      // R3 toggle at limit
        '{18'h00000, 1'b0, 1'b0, 1'b0, 17'h0},      // R5 pair closed
        '{18'h01111, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h10000, 1'b1, 1'b1, 1'b0, 17'h0},      // R3 early toggle
        '{18'h20000, 1'b1, 1'b0, 1'b0, 17'h0},      // R6 top bit in hunt
        '{18'h10000, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00000, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00001, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00002, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00003, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00004, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00005, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00006, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00007, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00008, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h10000, 1'b0, 1'b0, 1'b0, 17'h0},      // R5 open
        '{18'h1BEEF, 1'b0, 1'b0, 1'b0, 17'h0},      // R5 control word
        '{18'h00000, 1'b0, 1'b0, 1'b0, 17'h0},      // R5 close, count restarts
        '{18'h0F0F0, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b1, 17'h00001},  // R8 release at depth 16
        '{18'h0F0F0, 1'b0, 1'b0, 1'b1, 17'h00002},
        '{18'h0F0F0, 1'b0, 1'b0, 1'b1, 17'h00003},
        '{18'h0F0F0, 1'b1, 1'b1, 1'b0, 17'h0},      // R4 missing pair, R10
        '{18'h10000, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00000, 1'b0, 1'b0, 1'b0, 17'h0},
        '{18'h00001, 1'b0, 1'b0, 1'b0, 17'h0}
    };

    task automatic check(input logic e, input logic r, input logic v,
                         input logic [16:0] q, input string tag);
        logic ok;
        ok = (err_pulse === e) && (retx_req === r) && (rel_valid === v)
             && (!v || rel_word === q);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: err/retx/rel=%b%b%b word=%h expected %b%b%b word=%h",
                     tag, err_pulse, retx_req, rel_valid, rel_word, e, r, v, q);
        end
    endtask

    task automatic send(input logic [17:0] w, input logic e, input logic r,
                        input logic v, input logic [16:0] q, input string tag);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        check(e, r, v, q, tag);
    endtask

    task automatic do_reset(input logic deep, input logic [1:0] sel);
        rst_n        = 1'b0;
        in_valid     = 1'b0;
        cfg_deep     = deep;
        cfg_interval = sel;
        repeat (3) @(negedge clk);
        check(1'b0, 1'b0, 1'b0, 17'h0, "R11 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(1'b0, 1'b0, 1'b0, 17'h0, "R11 after reset");
    endtask

    task automatic sync_pair();
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 arm");
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 lock");
    endtask

    initial begin
        @(negedge clk);
        do_reset(1'b0, 2'd0);

        for (int i = 0; i < NV; i++) begin
            send(TBL[i].w, TBL[i].e, TBL[i].r, TBL[i].v, TBL[i].q, "R1-table");
        end

        // R1: non-zero first word after a toggle to 1
        do_reset(1'b0, 2'd0);
        sync_pair();
        for (int i = 0; i < 8; i++) send(18'h00042, 1'b0, 1'b0, 1'b0, 17'h0, "R1 data");
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R1 open");
        send(18'h00007, 1'b1, 1'b1, 1'b0, 17'h0, "R1 nonzero after change");
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 hunting after error");

        // R6: top bit while synchronised
        sync_pair();
        send(18'h20001, 1'b1, 1'b1, 1'b0, 17'h0, "R6 top bit synced");
        // R2: repeated flag-1 zero words keep the hunt armed
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 arm");
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 stay armed");
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R2 lock");
        send(18'h00011, 1'b0, 1'b0, 1'b0, 17'h0, "R2 accepted data");

        // R5: control frame closed by a non-zero word
        do_reset(1'b0, 2'd0);
        sync_pair();
        for (int i = 0; i < 8; i++) send(18'h00042, 1'b0, 1'b0, 1'b0, 17'h0, "R5 data");
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R5 open");
        send(18'h13333, 1'b0, 1'b0, 1'b0, 17'h0, "R5 control");
        send(18'h13334, 1'b0, 1'b0, 1'b0, 17'h0, "R5 second control");
        send(18'h00009, 1'b1, 1'b1, 1'b0, 17'h0, "R5 nonzero close");

        // R7: flushed words never come out after resync
        do_reset(1'b0, 2'd0);
        sync_pair();
        for (int i = 0; i < 8; i++) send(18'h00200 + 18'(i), 1'b0, 1'b0, 1'b0, 17'h0, "R7 old");
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R7 open");
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R7 close");
        for (int i = 0; i < 5; i++) send(18'h00280 + 18'(i), 1'b0, 1'b0, 1'b0, 17'h0, "R7 old");
        send(18'h20001, 1'b1, 1'b1, 1'b0, 17'h0, "R7 error");
        sync_pair();
        for (int i = 0; i < 8; i++) send(18'h00100 + 18'(i), 1'b0, 1'b0, 1'b0, 17'h0, "R7 flushed");
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R7 flushed");
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R7 flushed");
        for (int i = 0; i < 6; i++) send(18'h00180 + 18'(i), 1'b0, 1'b0, 1'b0, 17'h0, "R7 flushed");
        send(18'h00186, 1'b0, 1'b0, 1'b1, 17'h00100, "R8 first of new run");

        // R9: depth 32, interval 64, later config changes ignored
        do_reset(1'b1, 2'd3);
        send(18'h10000, 1'b0, 1'b0, 1'b0, 17'h0, "R9 arm");
        cfg_deep     = 1'b0;
        cfg_interval = 2'd0;
        send(18'h00000, 1'b0, 1'b0, 1'b0, 17'h0, "R9 lock");
        for (int i = 0; i < 64; i++) begin
            send(18'(i + 1), 1'b0, 1'b0, (i >= 32), 17'(i - 31), "R9 depth32 interval64");
        end
        send(18'h10000, 1'b0, 1'b0, 1'b1, 17'd33, "R3 toggle at 64");
        send(18'h1BEEF, 1'b0, 1'b0, 1'b1, 17'd34, "R5 control");
        send(18'h00000, 1'b0, 1'b0, 1'b1, 17'd35, "R5 close");
        for (int j = 0; j < 32; j++) begin
            if (j <= 28)
                send(18'h00500, 1'b0, 1'b0, 1'b1, 17'(36 + j), "R8 data release");
            else if (j == 30)
                send(18'h00500, 1'b0, 1'b0, 1'b1, 17'h1BEEF, "R8 control release");
            else
                send(18'h00500, 1'b0, 1'b0, 1'b0, 17'h0, "R8 check slot silent");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule